// File: doc/BRIEF.md
# Embedded Sync Code Channel Demultiplexer

This block sits on the 8-bit byte stream of a camera-style video source in which several logical video streams are interleaved. It searches the stream for four-byte synchronization codes (a three-byte preamble followed by a code byte) and decodes from each code byte a logical channel number and a line or frame event. Pixel bytes found between a line start and the matching line end are steered to one of several output lanes. Each lane carries its own valid strobe, start-of-frame pulse and end-of-line pulse.

The lane that each logical channel uses comes from a static configuration vector, so the host decides where every stream lands. A frame start latches its channel for the whole frame, and line starts that disagree with it are flagged. Codes with an out-of-range channel or an unknown event value are reported, and the bytes that follow them are dropped. Every byte is held in a short look-ahead window so that sync bytes never leak out as pixels. A preamble that turns out to be a false start flows out unchanged as ordinary data.

Top module: `sync_chan_demux`

## Requirements
- R1: A sync code is the byte sequence 0xFF, 0x00, 0x00, C, accepted on four consecutive `in_valid` cycles (idle cycles between them allowed). C[7:4] is the channel and C[3:0] the event: 0 line start, 1 line end, 2 frame start, 3 frame end. None of the four code bytes ever appears on a lane.
- R2: A byte accepted while a line is open (after a legal line start, before the next line end, illegal code, frame start, frame end or reset) is forwarded on exactly one lane. All other non-code bytes are discarded.
- R3: A forwarded byte appears on its lane, registered, in the cycle that follows the acceptance of the third byte after it. Any bytes still held when a line closes are pushed out by that code's preamble, so they come out before the line-end pulse.
- R4: A partial preamble that is broken by a later byte (for example 0xFF, 0x00, 0x05 or 0xFF, 0xFF, 0x00, 0x11) is forwarded as data, byte for byte and in order.
- R5: The lane for channel k is `chan_map[k*MAP_W +: MAP_W]`. The lane is chosen from the channel of the line start that opened the line.
- R6: A code whose channel is at least NUM_CHAN (7 by default) or whose event value is above 3 raises `code_err` for one cycle, registered the cycle after its code byte. It closes any open line without an end-of-line pulse, and data is then discarded until the next legal line start.
- R7: A frame start latches its channel. A legal line start received while a frame is latched and carrying a different channel pulses `chan_mismatch` for one cycle. That line is still forwarded using its own channel.
- R8: The first byte forwarded after a frame start carries `out_sof` on its lane in the same cycle as its valid strobe. No other byte carries it.
- R9: A line end received while a line is open pulses `out_eol` for one cycle on the lane of that line, in the cycle after the code byte. The line end's own channel field is not used.
- R10: A frame end clears the latched channel, so a following line start with any channel raises no mismatch.
- R11: A synchronous reset empties the look-ahead window, closes the line, drops the latched frame and any pending start-of-frame, and drives every output low.
- R12: At most one lane is valid, and at most one lane pulses end-of-line, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| chan_map | input | NUM_CHAN*MAP_W | Lane index for each logical channel, channel 0 in the low bits |
| out_valid | output | NUM_OUT | Per-lane data strobe |
| out_data | output | NUM_OUT*8 | Per-lane pixel byte, lane 0 in the low bits |
| out_sof | output | NUM_OUT | Per-lane start-of-frame pulse, with the first byte |
| out_eol | output | NUM_OUT | Per-lane end-of-line pulse |
| code_err | output | 1 | Illegal channel or event in a sync code |
| chan_mismatch | output | 1 | Line start channel differs from the latched frame channel |

## Verification
A stuck line-open state shows up as filler bytes appearing on a lane within four accepted bytes of a line end. A wrong latched frame channel shows up as a spurious or missing mismatch pulse on the very next line start. A bad look-ahead window shows up as preamble bytes leaking onto a lane, or as data arriving at the wrong accepted-byte count. The scoreboard compares every lane event, in order, against the accepted-byte count at which it is due, so a one-cycle slip or a wrong lane is reported at the event itself.

// File: rtl/sync_demux_pkg.sv
package sync_demux_pkg;

   localparam int BYTE_W = 8;
   localparam int FIELD_W = 4;

   typedef enum logic [FIELD_W-1:0] {
      EVT_LINE_OPEN   = 4'd0,
      EVT_LINE_CLOSE  = 4'd1,
      EVT_FRAME_OPEN  = 4'd2,
      EVT_FRAME_CLOSE = 4'd3
   } sync_event_e;

   localparam logic [FIELD_W-1:0] EVT_LAST = 4'd3;

   typedef struct packed {
      logic               hit;
      logic [FIELD_W-1:0] chan;
      logic [FIELD_W-1:0] kind;
   } sync_hit_t;

   // preamble byte at position pos (0 = first on the wire)
   function automatic logic [BYTE_W-1:0] preamble_byte(input int pos);
      return (pos == 0) ? 8'hFF : 8'h00;
   endfunction

endpackage

// File: rtl/sdm_sync_window.sv
module sdm_sync_window
   import sync_demux_pkg::*;
#(
   parameter int PRE_LEN = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              fwd_valid,
   output logic [BYTE_W-1:0] fwd_data,
   output sync_hit_t         hit
);

   localparam int OLDEST = PRE_LEN - 1;

   // slot 0 holds the newest byte
   logic [BYTE_W-1:0] slot_d [PRE_LEN];
   logic [PRE_LEN-1:0] slot_v;
   logic pre_seen;

   always_comb begin
      pre_seen = &slot_v;
      for (int i = 0; i < PRE_LEN; i++) begin
         if (slot_d[OLDEST-i] != preamble_byte(i)) pre_seen = 1'b0;
      end
   end

   assign hit.hit  = in_valid && pre_seen;
   assign hit.chan = in_data[BYTE_W-1:FIELD_W];
   assign hit.kind = in_data[FIELD_W-1:0];

   assign fwd_valid = in_valid && !pre_seen && slot_v[OLDEST];
   assign fwd_data  = slot_d[OLDEST];

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_v <= '0;
      end else if (in_valid) begin
         if (pre_seen) slot_v <= '0;
         else          slot_v <= {slot_v[PRE_LEN-2:0], 1'b1};
      end
   end

   for (genvar g = 0; g < PRE_LEN; g++) begin : g_slot
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (in_valid) slot_d[0] <= in_data;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (in_valid) slot_d[g] <= slot_d[g-1];
         end
      end
   end

endmodule

// File: rtl/sdm_code_decoder.sv
module sdm_code_decoder
   import sync_demux_pkg::*;
#(
   parameter int NUM_CHAN = 7,
   parameter int MAP_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  sync_hit_t                 hit,
   input  logic                      fwd_valid,
   input  logic [BYTE_W-1:0]         fwd_data,
   input  logic [NUM_CHAN*MAP_W-1:0] chan_map,
   output logic                      pix_fire,
   output logic [MAP_W-1:0]          pix_lane,
   output logic [BYTE_W-1:0]         pix_data,
   output logic                      pix_sof,
   output logic                      eol_fire,
   output logic                      err_fire,
   output logic                      mis_fire
);

   localparam logic [FIELD_W-1:0] CHAN_TOP = FIELD_W'(NUM_CHAN - 1);

   logic               line_open_q;
   logic [FIELD_W-1:0] line_chan_q;
   logic               frame_held_q;
   logic [FIELD_W-1:0] frame_chan_q;
   logic               sof_due_q;
   logic               legal;
   sync_event_e        kind;

   function automatic logic [MAP_W-1:0] lane_of(input logic [FIELD_W-1:0] ch,
                                                input logic [NUM_CHAN*MAP_W-1:0] map);
      logic [MAP_W-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_CHAN; i++) begin
         if (ch == FIELD_W'(i)) r = map[i*MAP_W +: MAP_W];
      end
      return r;
   endfunction

   assign legal = (hit.chan <= CHAN_TOP) && (hit.kind <= EVT_LAST);
   assign kind  = sync_event_e'(hit.kind);

   assign pix_fire = fwd_valid && line_open_q;
   assign pix_lane = lane_of(line_chan_q, chan_map);
   assign pix_data = fwd_data;
   assign pix_sof  = sof_due_q;
   assign eol_fire = hit.hit && legal && (kind == EVT_LINE_CLOSE) && line_open_q;
   assign err_fire = hit.hit && !legal;
   assign mis_fire = hit.hit && legal && (kind == EVT_LINE_OPEN)
                     && frame_held_q && (hit.chan != frame_chan_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         line_open_q  <= 1'b0;
         line_chan_q  <= '0;
         frame_held_q <= 1'b0;
         frame_chan_q <= '0;
         sof_due_q    <= 1'b0;
      end else begin
         if (pix_fire) sof_due_q <= 1'b0;
         if (hit.hit) begin
            if (!legal) begin
               line_open_q <= 1'b0;
            end else begin
               unique case (kind)
                  EVT_LINE_OPEN: begin
                     line_open_q <= 1'b1;
                     line_chan_q <= hit.chan;
                  end
                  EVT_LINE_CLOSE: line_open_q <= 1'b0;
                  EVT_FRAME_OPEN: begin
                     line_open_q  <= 1'b0;
                     frame_held_q <= 1'b1;
                     frame_chan_q <= hit.chan;
                     sof_due_q    <= 1'b1;
                  end
                  EVT_FRAME_CLOSE: begin
                     line_open_q  <= 1'b0;
                     frame_held_q <= 1'b0;
                     sof_due_q    <= 1'b0;
                  end
                  default: line_open_q <= 1'b0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/sdm_out_lanes.sv
module sdm_out_lanes
   import sync_demux_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int MAP_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       pix_fire,
   input  logic [MAP_W-1:0]           pix_lane,
   input  logic [BYTE_W-1:0]          pix_data,
   input  logic                       pix_sof,
   input  logic                       eol_fire,
   input  logic                       err_fire,
   input  logic                       mis_fire,
   output logic [NUM_OUT-1:0]         out_valid,
   output logic [NUM_OUT*BYTE_W-1:0]  out_data,
   output logic [NUM_OUT-1:0]         out_sof,
   output logic [NUM_OUT-1:0]         out_eol,
   output logic                       code_err,
   output logic                       chan_mismatch
);

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
      logic sel;
      assign sel = (pix_lane == MAP_W'(o));

      always_ff @(posedge clk) begin
         if (rst) begin
            out_valid[o] <= 1'b0;
            out_sof[o]   <= 1'b0;
            out_eol[o]   <= 1'b0;
         end else begin
            out_valid[o] <= pix_fire && sel;
            out_sof[o]   <= pix_fire && sel && pix_sof;
            out_eol[o]   <= eol_fire && sel;
         end
      end

      always_ff @(posedge clk) begin
         if (rst)                out_data[o*BYTE_W +: BYTE_W] <= '0;
         else if (pix_fire && sel) out_data[o*BYTE_W +: BYTE_W] <= pix_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code_err      <= 1'b0;
         chan_mismatch <= 1'b0;
      end else begin
         code_err      <= err_fire;
         chan_mismatch <= mis_fire;
      end
   end

endmodule

// File: rtl/sync_chan_demux.sv
module sync_chan_demux
   import sync_demux_pkg::*;
#(
   parameter int NUM_CHAN = 7,
   parameter int NUM_OUT  = 4,
   parameter int SYNC_LEN = 4,
   localparam int MAP_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
   localparam int PRE_LEN = SYNC_LEN - 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [7:0]                 in_data,
   input  logic [NUM_CHAN*MAP_W-1:0]  chan_map,
   output logic [NUM_OUT-1:0]         out_valid,
   output logic [NUM_OUT*8-1:0]       out_data,
   output logic [NUM_OUT-1:0]         out_sof,
   output logic [NUM_OUT-1:0]         out_eol,
   output logic                       code_err,
   output logic                       chan_mismatch
);

   if (NUM_CHAN < 1 || NUM_CHAN > 16) begin : g_bad_chan
      $error("NUM_CHAN must fit the 4-bit channel field");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      $error("NUM_OUT must be at least 1");
   end
   if (SYNC_LEN < 3) begin : g_bad_len
      $error("SYNC_LEN must be at least 3");
   end

   logic              fwd_valid;
   logic [BYTE_W-1:0] fwd_data;
   sync_hit_t         hit;
   logic              pix_fire;
   logic [MAP_W-1:0]  pix_lane;
   logic [BYTE_W-1:0] pix_data;
   logic              pix_sof;
   logic              eol_fire;
   logic              err_fire;
   logic              mis_fire;

   sdm_sync_window #(.PRE_LEN(PRE_LEN)) window_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .fwd_valid (fwd_valid),
      .fwd_data  (fwd_data),
      .hit       (hit)
   );

   sdm_code_decoder #(.NUM_CHAN(NUM_CHAN), .MAP_W(MAP_W)) decode_i (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit),
      .fwd_valid (fwd_valid),
      .fwd_data  (fwd_data),
      .chan_map  (chan_map),
      .pix_fire  (pix_fire),
      .pix_lane  (pix_lane),
      .pix_data  (pix_data),
      .pix_sof   (pix_sof),
      .eol_fire  (eol_fire),
      .err_fire  (err_fire),
      .mis_fire  (mis_fire)
   );

   sdm_out_lanes #(.NUM_OUT(NUM_OUT), .MAP_W(MAP_W)) lanes_i (
      .clk           (clk),
      .rst           (rst),
      .pix_fire      (pix_fire),
      .pix_lane      (pix_lane),
      .pix_data      (pix_data),
      .pix_sof       (pix_sof),
      .eol_fire      (eol_fire),
      .err_fire      (err_fire),
      .mis_fire      (mis_fire),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_sof       (out_sof),
      .out_eol       (out_eol),
      .code_err      (code_err),
      .chan_mismatch (chan_mismatch)
   );

endmodule

// File: rtl/sync_chan_demux_chk.sv
module sync_chan_demux_chk #(
   parameter int NUM_OUT = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic [NUM_OUT-1:0] out_valid,
   input logic [NUM_OUT-1:0] out_sof,
   input logic [NUM_OUT-1:0] out_eol,
   input logic               code_err,
   input logic               chan_mismatch
);

   assert_one_lane_R12: assert property (@(posedge clk) disable iff (rst)
      $onehot0(out_valid));

   assert_one_eol_R12: assert property (@(posedge clk) disable iff (rst)
      $onehot0(out_eol));

   assert_sof_on_data_R8: assert property (@(posedge clk) disable iff (rst)
      (|out_sof) |-> ((out_sof & ~out_valid) == '0));

   assert_data_needs_input_R3: assert property (@(posedge clk) disable iff (rst)
      (|out_valid) |-> $past(in_valid));

   assert_err_needs_input_R6: assert property (@(posedge clk) disable iff (rst)
      code_err |-> $past(in_valid));

   assert_code_not_data_R1: assert property (@(posedge clk) disable iff (rst)
      (code_err || chan_mismatch || (|out_eol)) |-> (out_valid == '0));

   assert_err_excludes_mis_R7: assert property (@(posedge clk) disable iff (rst)
      !(code_err && chan_mismatch));

   assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_valid == '0 && out_eol == '0 && !code_err && !chan_mismatch));

endmodule

bind sync_chan_demux sync_chan_demux_chk #(.NUM_OUT(NUM_OUT)) chk_i (
   .clk           (clk),
   .rst           (rst),
   .in_valid      (in_valid),
   .out_valid     (out_valid),
   .out_sof       (out_sof),
   .out_eol       (out_eol),
   .code_err      (code_err),
   .chan_mismatch (chan_mismatch)
);

// File: tb/sync_chan_demux_tb_top.sv
module sync_chan_demux_tb_top;

   localparam int NCH  = 7;
   localparam int NOUT = 4;
   localparam int MW   = 2;

   localparam int K_DATA = 0;
   localparam int K_EOL  = 1;
   localparam int K_ERR  = 2;
   localparam int K_MIS  = 3;

   typedef struct {
      int       kind;
      int       lane;
      logic [7:0] data;
      bit       sof;
      int       at;
      string    req;
   } item_t;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic [7:0]           in_data = 8'h00;
   logic [NCH*MW-1:0]    chan_map;
   logic [NOUT-1:0]      out_valid;
   logic [NOUT*8-1:0]    out_data;
   logic [NOUT-1:0]      out_sof;
   logic [NOUT-1:0]      out_eol;
   logic                 code_err;
   logic                 chan_mismatch;

   int n_cmp = 0;
   int n_bad = 0;
   int in_count = 0;
   item_t q[$];

   // model state
   bit m_line = 0;
   int m_lch = 0;
   bit m_frame = 0;
   int m_fch = 0;
   bit m_sof = 0;

   always #10 clk = ~clk;

   sync_chan_demux dut_i (
      .clk           (clk),
      .rst           (rst),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .chan_map      (chan_map),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_sof       (out_sof),
      .out_eol       (out_eol),
      .code_err      (code_err),
      .chan_mismatch (chan_mismatch)
   );

   function automatic int lane_for(int ch);
      return int'(chan_map[ch*MW +: MW]);
   endfunction

   task automatic push(int kind, int lane, logic [7:0] d, bit s, int at, string req);
      item_t it;
      it.kind = kind; it.lane = lane; it.data = d; it.sof = s; it.at = at; it.req = req;
      q.push_back(it);
   endtask

   task automatic send_byte(logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(posedge clk);
      in_count++;
   endtask

   task automatic gap(int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   // R2 R3: pixel byte, forwarded three accepted bytes later if a line is open
   task automatic send_pix(logic [7:0] b);
      send_byte(b);
      if (m_line) begin
         push(K_DATA, lane_for(m_lch), b, m_sof, in_count + 3, m_sof ? "R8" : "R2");
         m_sof = 0;
      end
   endtask

   task automatic send_pixels(int n, int seed);
      for (int i = 0; i < n; i++) send_pix(8'((i * 37 + seed * 11) & 8'h7F));
   endtask

   // R1 code: preamble then code byte
   task automatic send_code(int ch, int ev);
      send_byte(8'hFF);
      send_byte(8'h00);
      send_byte(8'h00);
      send_byte({4'(ch), 4'(ev)});
      if (ch >= NCH || ev > 3) begin
         push(K_ERR, 0, 8'h00, 0, in_count, "R6");
         m_line = 0;
      end else begin
         case (ev)
            0: begin
               if (m_frame && ch != m_fch) push(K_MIS, 0, 8'h00, 0, in_count, "R7");
               m_line = 1; m_lch = ch;
            end
            1: begin
               if (m_line) push(K_EOL, lane_for(m_lch), 8'h00, 0, in_count, "R9");
               m_line = 0;
            end
            2: begin m_frame = 1; m_fch = ch; m_sof = 1; m_line = 0; end
            default: begin m_frame = 0; m_sof = 0; m_line = 0; end
         endcase
      end
   endtask

   task automatic expect_evt(int kind, int lane, logic [7:0] d, bit s);
      item_t it;
      n_cmp++;
      if (q.size() == 0) begin
         n_bad++;
         $display("FAIL unexpected event kind=%0d lane=%0d data=%h sof=%0d at=%0d (expected none) R2",
                  kind, lane, d, s, in_count);
      end else begin
         it = q.pop_front();
         if (it.kind != kind || it.lane != lane || it.sof != s || it.at != in_count
             || (kind == K_DATA && it.data != d)) begin
            n_bad++;
            $display("FAIL %s got kind=%0d lane=%0d data=%h sof=%0d at=%0d expected kind=%0d lane=%0d data=%h sof=%0d at=%0d",
                     it.req, kind, lane, d, s, in_count, it.kind, it.lane, it.data, it.sof, it.at);
         end
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         for (int l = 0; l < NOUT; l++) begin
            if (out_valid[l]) expect_evt(K_DATA, l, out_data[l*8 +: 8], out_sof[l]);
            if (out_eol[l])   expect_evt(K_EOL, l, 8'h00, 1'b0);
         end
         if (code_err)      expect_evt(K_ERR, 0, 8'h00, 1'b0);
         if (chan_mismatch) expect_evt(K_MIS, 0, 8'h00, 1'b0);
      end
   end

   task automatic set_map(bit reversed);
      for (int c = 0; c < NCH; c++)
         chan_map[c*MW +: MW] = reversed ? MW'(3 - (c % 4)) : MW'(c % 4);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired (expected run to end)");
      finish_run();
   end

   initial begin
      set_map(0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state at the ports
      n_cmp++;
      if (out_valid != '0 || out_sof != '0 || out_eol != '0 || code_err || chan_mismatch) begin
         n_bad++;
         $display("FAIL R11 reset outputs valid=%b sof=%b eol=%b err=%b mis=%b expected all zero",
                  out_valid, out_sof, out_eol, code_err, chan_mismatch);
      end

      // R1 R2 R3 R8 R9: one frame, two lines on channel 2, filler between lines
      send_code(2, 2);
      send_code(2, 0);
      send_pixels(6, 1);
      send_code(2, 1);
      send_pix(8'h10); send_pix(8'h11); send_pix(8'h12);
      send_code(2, 0);
      send_pixels(2, 2);
      gap(3);                     // R3: stalls do not move the byte count
      send_pixels(3, 3);
      send_code(2, 1);
      send_code(2, 3);

      // R7: frame on channel 5, then a line start on channel 0
      send_code(5, 2);
      send_code(5, 0);
      send_pixels(4, 4);
      send_code(5, 1);
      send_code(0, 0);
      send_pixels(3, 5);
      send_code(0, 1);
      send_code(5, 3);
      // R10: no frame latched, line start gives no mismatch
      send_code(6, 0);
      send_pixels(2, 6);
      send_code(6, 1);

      // R4: broken preambles travel as data
      send_code(1, 2);
      send_code(1, 0);
      send_pix(8'hFF); send_pix(8'h00); send_pix(8'h05);
      send_pix(8'hFF); send_pix(8'hFF); send_pix(8'h00); send_pix(8'h11);
      send_pix(8'h22);
      send_code(1, 1);

      // R6: illegal channel, then illegal event inside an open line
      send_code(7, 0);
      send_pixels(3, 7);
      send_code(0, 1);
      send_code(3, 0);
      send_pixels(3, 8);
      send_code(3, 5);
      send_pixels(2, 9);
      send_code(3, 1);
      send_code(1, 3);
      send_code(15, 2);
      gap(2);

      // R5: reversed mapping
      set_map(1);
      send_code(4, 2);
      send_code(4, 0);
      send_pixels(4, 10);
      send_code(4, 1);
      send_code(4, 3);
      send_code(6, 0);
      send_pixels(2, 11);
      send_code(6, 1);
      gap(2);

      // R11: reset in the middle of a frame and line
      send_code(3, 2);
      send_code(3, 0);
      send_byte(8'h44);
      send_byte(8'h45);
      gap(1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_line = 0; m_frame = 0; m_sof = 0;
      send_code(1, 0);            // no mismatch, no sof after reset
      send_pixels(3, 12);
      send_code(1, 1);
      gap(4);

      // everything expected must have appeared
      n_cmp++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 %0d events never seen, expected 0 outstanding (first due at %0d, req %s)",
                  q.size(), q[0].at, q[0].req);
      end
      finish_run();
   end

endmodule